// File: doc/BRIEF.md
# Bank-Switched Ethernet MAC Control Register File

This block holds the control and status registers of a small Ethernet MAC behind a narrow, bank-switched 16-bit port. A 3-bit offset selects one of eight words. The low three bits of the bank word pick which set of registers offsets 0 to 6 reach. Offset 7 reaches the bank word in every bank. Each write is merged under the byte enables and the register's own writable mask. The block compares the value before and after each write. From that comparison it raises one-cycle pulses that the surrounding datapath uses: drop the received-frame queue, reapply the promiscuous setting, reset the buffer manager, acknowledge a link interrupt and load a new station address.

A packet data port reads and writes a small byte buffer at an 11-bit pointer. The port is aware of byte lanes and can advance the pointer after each access. Buffer allocation appears only as a strobe that lowers the free-page count in the memory-information word. A buffer-manager reset command restores that count.

Top module: `eth_regbank`

## Requirements
- R1: A write sets a bit only where its byte lane is enabled (`be[0]` = bits 7:0, `be[1]` = bits 15:8) and the register's writable mask is 1. The masks are: transmit control (bank 0, offset 0) 0x3D87, receive control (bank 0, offset 2) 0xC307, memory config (bank 0, offset 5) 0x00FF, link control (bank 1, offset 6) 0x68E7. All other bits keep their value.
- R2: After reset the registers hold these values: status (bank 0, offset 1) 0x4000, bank word 0x3330, memory config 0x3300, link control 0x0100, receive control 0x0000. `prom_o` is 0 after reset.
- R3: Only bits 2:0 of the bank word (offset 7, in any bank) are writable. They select the bank that offsets 0 to 6 decode.
- R4: `rxq_clr_o` pulses only when receive-enable (receive control bit 8) goes from 1 to 0. A write that leaves the bit at 0 gives no pulse.
- R5: `prom_upd_o` pulses whenever the promiscuous bit (receive control bit 1) changes, in either direction. `prom_o` follows the bit.
- R6: A `link_chg_i` pulse sets the link flag, which reads as bit 5 at bank 2, offset 6. The flag is cleared, with a `link_clr_o` pulse, only when link-interrupt-enable (link control bit 7) goes from 1 to 0.
- R7: The memory-information word (bank 0, offset 4) is read-only. It resets to 0x1818 when DEV_LARGE=1 and to 0x1212 when DEV_LARGE=0. The revision word (bank 3, offset 5) reads 0x3346 or 0x3345 to match. Each `alloc_i` pulse lowers the high byte by 1, stopping at 0.
- R8: Writing code 2 in bits 7:5 of bank 2, offset 0 with `be[0]` set pulses `mmu_rst_o`. The same write copies the low byte of the memory-information word into its high byte.
- R9: An access to the data port (bank 2, offset 4) uses the low byte at the pointer only if `be[0]` is set. It uses the high byte at pointer+`be[0]` only if `be[1]` is set. A read returns 0 on a lane that is not enabled.
- R10: The pointer (bank 2, offset 3; field in bits 10:0, auto-increment flag in bit 14, writable mask 0xE7FF) advances by one for each enabled lane after a data access. It advances only when bit 14 is set, and the field wraps at 11 bits.
- R11: The status word is read-only, so writing it leaves 0x4000.
- R12: `mac_upd_o` pulses only when the upper byte of the last station-address word (bank 1, offset 4) is written. `mac_o` is {offset 4, offset 3, offset 2} of bank 1.
- R13: Each side-effect output is high for exactly the one cycle after the clock edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Word offset within the selected bank |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only at the data port) |
| be | input | 2 | Byte-lane enables |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| link_chg_i | input | 1 | Link status change event |
| alloc_i | input | 1 | One buffer page allocated |
| rxq_clr_o | output | 1 | Pulse: clear received-frame queue |
| prom_upd_o | output | 1 | Pulse: promiscuous setting changed |
| prom_o | output | 1 | Current promiscuous setting |
| mmu_rst_o | output | 1 | Pulse: buffer manager reset |
| link_clr_o | output | 1 | Pulse: link interrupt acknowledged |
| mac_upd_o | output | 1 | Pulse: station address committed |
| mac_o | output | 48 | Station address |

## Verification
Writes to the receive and link control words are repeated with the same value, set and cleared. This shows that a pulse follows a transition and not merely a write or a written 0. Data-port accesses use all three lane patterns, with auto-increment on and off and at the 11-bit wrap. This separates per-lane addressing from a fixed two-byte step. Partial-lane writes to masked registers show whether the byte enable and the writable mask are ANDed or only one of them is applied. The station-address word is written low lane first and then high lane, so that only the second write commits the address.

// File: rtl/eth_rb_pkg.sv
package eth_rb_pkg;

  localparam int OFS_W = 3;
  localparam int BSEL_W = 3;

  localparam int RXEN_BIT = 8;
  localparam int PRMS_BIT = 1;
  localparam int LE_BIT = 7;
  localparam int LINKF_BIT = 5;
  localparam int PTR_AUTO_BIT = 14;
  localparam int PTR_FLD_W = 11;
  localparam logic [2:0] CMD_MMU_RST = 3'd2;

  localparam logic [15:0] STAT_RST = 16'h4000;
  localparam logic [15:0] PTR_WMASK = 16'he7ff;

  typedef enum logic [4:0] {
    ID_TCR, ID_RCR, ID_MCR, ID_CFG, ID_BASE, ID_IA01, ID_IA23, ID_IA45,
    ID_GP, ID_CTL, ID_PNR, ID_INTM, ID_BANK,
    ID_STAT, ID_CNT, ID_MIR, ID_MMU, ID_PTR, ID_DATA, ID_REV, ID_NONE
  } reg_id_e;

  localparam int N_GEN = 13;

  function automatic logic [15:0] gen_rst(input int i);
    case (i)
      2:  return 16'h3300;
      3:  return 16'h0031;
      4:  return 16'h1866;
      9:  return 16'h0100;
      12: return 16'h3330;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] gen_wmask(input int i);
    case (i)
      0:  return 16'h3d87;
      1:  return 16'hc307;
      2:  return 16'h00ff;
      3:  return 16'h10c6;
      4:  return 16'hfffe;
      9:  return 16'h68e7;
      10: return 16'h001f;
      11: return 16'hff00;
      12: return 16'h0007;
      default: return 16'hffff;
    endcase
  endfunction

  function automatic logic [15:0] merge16(input logic [15:0] old_v, input logic [15:0] d,
                                          input logic [1:0] be, input logic [15:0] wm);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}} & wm;
    return (old_v & ~m) | (d & m);
  endfunction

  function automatic logic [15:0] ptr_advance(input logic [15:0] p, input logic [1:0] be);
    logic [PTR_FLD_W-1:0] f;
    f = p[PTR_FLD_W-1:0] + PTR_FLD_W'(be[0]) + PTR_FLD_W'(be[1]);
    return p[PTR_AUTO_BIT] ? {p[15:PTR_FLD_W], f} : p;
  endfunction

  function automatic reg_id_e decode(input logic [BSEL_W-1:0] b, input logic [OFS_W-1:0] o);
    if (o == 3'd7) return ID_BANK;
    case (b)
      3'd0: case (o)
        3'd0: return ID_TCR;  3'd1: return ID_STAT; 3'd2: return ID_RCR;
        3'd3: return ID_CNT;  3'd4: return ID_MIR;  3'd5: return ID_MCR;
        default: return ID_NONE;
      endcase
      3'd1: case (o)
        3'd0: return ID_CFG;  3'd1: return ID_BASE; 3'd2: return ID_IA01;
        3'd3: return ID_IA23; 3'd4: return ID_IA45; 3'd5: return ID_GP;
        default: return ID_CTL;
      endcase
      3'd2: case (o)
        3'd0: return ID_MMU;  3'd1: return ID_PNR;  3'd3: return ID_PTR;
        3'd4: return ID_DATA; 3'd6: return ID_INTM;
        default: return ID_NONE;
      endcase
      3'd3: return (o == 3'd5) ? ID_REV : ID_NONE;
      default: return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rb_word.sv
module rb_word
  import eth_rb_pkg::*;
#(
  parameter logic [15:0] RST = 16'h0000,
  parameter logic [15:0] WMASK = 16'hffff
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] q,
  output logic [15:0] nxt
);
  assign nxt = we ? merge16(q, wdata, be, WMASK) : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST;
    else        q <= nxt;
  end
endmodule

// File: rtl/rb_events.sv
module rb_events
  import eth_rb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] rcr_q,
  input  logic [15:0] rcr_nxt,
  input  logic [15:0] ctl_q,
  input  logic [15:0] ctl_nxt,
  input  logic        link_chg_i,
  input  logic        mac_commit,
  output logic        rxq_clr_o,
  output logic        prom_upd_o,
  output logic        link_clr_o,
  output logic        mac_upd_o,
  output logic        link_flag
);
  logic rx_off_edge, prom_edge, le_off_edge;

  assign rx_off_edge = rcr_q[RXEN_BIT] & ~rcr_nxt[RXEN_BIT];
  assign prom_edge   = rcr_q[PRMS_BIT] ^ rcr_nxt[PRMS_BIT];
  assign le_off_edge = ctl_q[LE_BIT] & ~ctl_nxt[LE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxq_clr_o  <= 1'b0;
      prom_upd_o <= 1'b0;
      link_clr_o <= 1'b0;
      mac_upd_o  <= 1'b0;
      link_flag  <= 1'b0;
    end else begin
      rxq_clr_o  <= rx_off_edge;
      prom_upd_o <= prom_edge;
      link_clr_o <= le_off_edge;
      mac_upd_o  <= mac_commit;
      if (le_off_edge)     link_flag <= 1'b0;
      else if (link_chg_i) link_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rb_mmu.sv
module rb_mmu #(
  parameter logic [7:0] PAGES = 8'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [2:0]  cmd_code,
  input  logic        alloc_i,
  output logic [15:0] mir,
  output logic        mmu_rst_o
);
  logic do_rst;
  assign do_rst = cmd_wr && (cmd_code == eth_rb_pkg::CMD_MMU_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir       <= {PAGES, PAGES};
      mmu_rst_o <= 1'b0;
    end else begin
      mmu_rst_o <= do_rst;
      if (do_rst)
        mir <= {mir[7:0], mir[7:0]};
      else if (alloc_i && mir[15:8] != 8'd0)
        mir <= {mir[15:8] - 8'd1, mir[7:0]};
    end
  end
endmodule

// File: rtl/rb_dport.sv
module rb_dport
  import eth_rb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_we,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] ptr_q,
  output logic [15:0] rd_word
);
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] a0, a1;

  assign a0 = ptr_q[AW-1:0];
  assign a1 = a0 + AW'(be[0]);
  assign rd_word = {be[1] ? mem[a1] : 8'h00, be[0] ? mem[a0] : 8'h00};

  always_ff @(posedge clk) begin
    if (acc_wr) begin
      if (be[0]) mem[a0] <= wdata[7:0];
      if (be[1]) mem[a1] <= wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= 16'h0000;
    else if (ptr_we)
      ptr_q <= merge16(ptr_q, wdata, be, PTR_WMASK);
    else if (acc_wr || acc_rd)
      ptr_q <= ptr_advance(ptr_q, be);
  end
endmodule

// File: rtl/eth_regbank.sv
module eth_regbank
  import eth_rb_pkg::*;
#(
  parameter bit DEV_LARGE = 1'b1,
  parameter int BUF_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        link_chg_i,
  input  logic        alloc_i,
  output logic        rxq_clr_o,
  output logic        prom_upd_o,
  output logic        prom_o,
  output logic        mmu_rst_o,
  output logic        link_clr_o,
  output logic        mac_upd_o,
  output logic [47:0] mac_o
);
  localparam logic [7:0]  PAGES = DEV_LARGE ? 8'h18 : 8'h12;
  localparam logic [15:0] REV_ID = DEV_LARGE ? 16'h3346 : 16'h3345;

  logic [15:0] gq [N_GEN];
  logic [15:0] gnxt [N_GEN];
  reg_id_e     rid;
  logic [15:0] mir_w, ptr_w, dword;
  logic        link_flag_w, rxen_w;

  assign rid = decode(gq[ID_BANK][BSEL_W-1:0], addr);

  for (genvar g = 0; g < N_GEN; g++) begin : g_word
    rb_word #(.RST(gen_rst(g)), .WMASK(gen_wmask(g))) u_w (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (rid == reg_id_e'(g))),
      .be(be), .wdata(wdata), .q(gq[g]), .nxt(gnxt[g])
    );
  end

  rb_events u_ev (
    .clk(clk), .rst_n(rst_n),
    .rcr_q(gq[ID_RCR]), .rcr_nxt(gnxt[ID_RCR]),
    .ctl_q(gq[ID_CTL]), .ctl_nxt(gnxt[ID_CTL]),
    .link_chg_i(link_chg_i),
    .mac_commit(wr_en && rid == ID_IA45 && be[1]),
    .rxq_clr_o(rxq_clr_o), .prom_upd_o(prom_upd_o),
    .link_clr_o(link_clr_o), .mac_upd_o(mac_upd_o), .link_flag(link_flag_w)
  );

  rb_mmu #(.PAGES(PAGES)) u_mmu (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(wr_en && rid == ID_MMU && be[0]),
    .cmd_code(wdata[7:5]), .alloc_i(alloc_i),
    .mir(mir_w), .mmu_rst_o(mmu_rst_o)
  );

  rb_dport #(.DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .ptr_we(wr_en && rid == ID_PTR),
    .acc_wr(wr_en && rid == ID_DATA),
    .acc_rd(rd_en && !wr_en && rid == ID_DATA),
    .be(be), .wdata(wdata), .ptr_q(ptr_w), .rd_word(dword)
  );

  assign rxen_w = gq[ID_RCR][RXEN_BIT];
  assign prom_o = gq[ID_RCR][PRMS_BIT];
  assign mac_o  = {gq[ID_IA45], gq[ID_IA23], gq[ID_IA01]};

  always_comb begin
    rdata = 16'h0000;
    case (rid)
      ID_STAT: rdata = STAT_RST;
      ID_MIR:  rdata = mir_w;
      ID_PTR:  rdata = ptr_w;
      ID_DATA: rdata = dword;
      ID_REV:  rdata = REV_ID;
      ID_INTM: rdata = {gq[ID_INTM][15:8], 8'(link_flag_w) << LINKF_BIT};
      ID_CNT, ID_MMU, ID_NONE: rdata = 16'h0000;
      default: rdata = gq[rid[3:0]];
    endcase
  end
endmodule

// File: rtl/rb_checker.sv
module rb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  be,
  input logic        rxen_w,
  input logic        prom_o,
  input logic        rxq_clr_o,
  input logic        prom_upd_o,
  input logic        link_clr_o,
  input logic        link_flag_w,
  input logic        mmu_rst_o,
  input logic        mac_upd_o,
  input logic [15:0] mir_w,
  input logic [15:0] ptr_w
);
  assert_rxq_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_clr_o |-> ($past(rxen_w) && !rxen_w));

  assert_prom_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prom_upd_o |-> (prom_o != $past(prom_o)));

  assert_prom_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prom_o != $past(prom_o)) |-> prom_upd_o);

  assert_link_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    link_clr_o |-> !link_flag_w);

  assert_mir_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_rst_o |-> (mir_w[15:8] == mir_w[7:0]));

  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(rd_en)) |-> $stable(ptr_w));

  assert_mac_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mac_upd_o |-> ($past(wr_en) && $past(be[1])));

  assert_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_rst_o |=> !mmu_rst_o || $past(wr_en));
endmodule

bind eth_regbank rb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .be(be),
  .rxen_w(rxen_w), .prom_o(prom_o), .rxq_clr_o(rxq_clr_o),
  .prom_upd_o(prom_upd_o), .link_clr_o(link_clr_o), .link_flag_w(link_flag_w),
  .mmu_rst_o(mmu_rst_o), .mac_upd_o(mac_upd_o), .mir_w(mir_w), .ptr_w(ptr_w)
);

// File: tb/sim_eth_regbank.sv
`timescale 1ns/1ps
module sim_eth_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, link_chg_i = 1'b0, alloc_i = 1'b0;
  logic [1:0] be = '0;
  logic [15:0] wdata = '0, rdata;
  logic rxq_clr_o, prom_upd_o, prom_o, mmu_rst_o, link_clr_o, mac_upd_o;
  logic [47:0] mac_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic p_rxq, p_prom, p_mmu, p_link, p_mac;
  logic [15:0] rv;

  always #2 clk = ~clk;

  eth_regbank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .be(be), .wdata(wdata), .rdata(rdata), .link_chg_i(link_chg_i), .alloc_i(alloc_i),
    .rxq_clr_o(rxq_clr_o), .prom_upd_o(prom_upd_o), .prom_o(prom_o), .mmu_rst_o(mmu_rst_o),
    .link_clr_o(link_clr_o), .mac_upd_o(mac_upd_o), .mac_o(mac_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk); addr = o; be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    p_rxq = rxq_clr_o; p_prom = prom_upd_o; p_mmu = mmu_rst_o;
    p_link = link_clr_o; p_mac = mac_upd_o;
  endtask

  task automatic rd(input logic [2:0] o, input logic [1:0] b, output logic [15:0] d);
    @(negedge clk); addr = o; be = b; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic bank(input logic [2:0] b);
    wr(3'd7, 2'b01, {13'd0, b});
  endtask

  task automatic t_reset;
    check("R2 prom_o", prom_o, 0);
    rd(3'd7, 2'b11, rv); check("R2 bank", rv, 16'h3330);
    rd(3'd1, 2'b11, rv); check("R2 status", rv, 16'h4000);
    rd(3'd5, 2'b11, rv); check("R2 mcr", rv, 16'h3300);
    rd(3'd2, 2'b11, rv); check("R2 rcr", rv, 16'h0000);
    bank(3'd1);
    rd(3'd6, 2'b11, rv); check("R2 ctl", rv, 16'h0100);
  endtask

  task automatic t_merge;
    bank(3'd0);
    wr(3'd0, 2'b01, 16'hffff); rd(3'd0, 2'b11, rv); check("R1 lane0", rv, 16'h0087);
    wr(3'd0, 2'b10, 16'hffff); rd(3'd0, 2'b11, rv); check("R1 lane1", rv, 16'h3d87);
    wr(3'd5, 2'b11, 16'h0000); rd(3'd5, 2'b11, rv); check("R1 mcr", rv, 16'h3300);
    wr(3'd1, 2'b11, 16'h0000); rd(3'd1, 2'b11, rv); check("R11 status", rv, 16'h4000);
    wr(3'd7, 2'b11, 16'hffff); rd(3'd7, 2'b11, rv); check("R3 bank mask", rv, 16'h3337);
    bank(3'd3); rd(3'd5, 2'b11, rv); check("R3 bank3 rev R7", rv, 16'h3346);
  endtask

  task automatic t_rcr;
    bank(3'd0);
    wr(3'd2, 2'b11, 16'hffff);
    check("R4 no clr on rise", p_rxq, 0); check("R5 rise", p_prom, 1);
    check("R5 prom_o", prom_o, 1);
    rd(3'd2, 2'b11, rv); check("R1 rcr", rv, 16'hc307);
    wr(3'd2, 2'b11, 16'h0000);
    check("R4 fall", p_rxq, 1); check("R5 fall", p_prom, 1); check("R5 prom_o0", prom_o, 0);
    @(negedge clk); check("R13 rxq width", rxq_clr_o, 0); check("R13 prom width", prom_upd_o, 0);
    wr(3'd2, 2'b11, 16'h0000);
    check("R4 zero again", p_rxq, 0); check("R5 same", p_prom, 0);
    wr(3'd2, 2'b01, 16'h0002); check("R5 low only", p_prom, 1);
    wr(3'd2, 2'b01, 16'h0002); check("R5 repeat", p_prom, 0);
  endtask

  task automatic t_link;
    bank(3'd2);
    @(negedge clk); link_chg_i = 1'b1; @(negedge clk); link_chg_i = 1'b0;
    rd(3'd6, 2'b11, rv); check("R6 set", rv, 16'h0020);
    bank(3'd1);
    wr(3'd6, 2'b11, 16'h0000); check("R6 no edge", p_link, 0);
    wr(3'd6, 2'b11, 16'h0180); check("R6 rise", p_link, 0);
    bank(3'd2); rd(3'd6, 2'b11, rv); check("R6 kept", rv, 16'h0020);
    bank(3'd1);
    wr(3'd6, 2'b01, 16'h0000); check("R6 fall", p_link, 1);
    bank(3'd2); rd(3'd6, 2'b11, rv); check("R6 cleared", rv, 16'h0000);
  endtask

  task automatic t_mmu;
    bank(3'd0);
    rd(3'd4, 2'b11, rv); check("R7 default", rv, 16'h1818);
    wr(3'd4, 2'b11, 16'h0000); rd(3'd4, 2'b11, rv); check("R7 read-only", rv, 16'h1818);
    repeat (2) begin @(negedge clk); alloc_i = 1'b1; @(negedge clk); alloc_i = 1'b0; end
    rd(3'd4, 2'b11, rv); check("R7 alloc", rv, 16'h1618);
    bank(3'd2);
    wr(3'd0, 2'b01, 16'h0020); check("R8 other code", p_mmu, 0);
    wr(3'd0, 2'b01, 16'h0040); check("R8 pulse", p_mmu, 1);
    @(negedge clk); check("R13 mmu width", mmu_rst_o, 0);
    bank(3'd0); rd(3'd4, 2'b11, rv); check("R8 mirror", rv, 16'h1818);
  endtask

  task automatic t_data;
    bank(3'd2);
    wr(3'd3, 2'b11, 16'h4010);
    wr(3'd4, 2'b11, 16'hbeef);
    wr(3'd4, 2'b01, 16'h0012);
    wr(3'd4, 2'b10, 16'h3400);
    rd(3'd3, 2'b11, rv); check("R10 auto", rv, 16'h4014);
    wr(3'd3, 2'b11, 16'h4010);
    rd(3'd4, 2'b11, rv); check("R9 both", rv, 16'hbeef);
    rd(3'd4, 2'b10, rv); check("R9 high only", rv, 16'h1200);
    rd(3'd4, 2'b01, rv); check("R9 low only", rv, 16'h0034);
    rd(3'd3, 2'b11, rv); check("R10 read adv", rv, 16'h4014);
    wr(3'd3, 2'b11, 16'h0010);
    rd(3'd4, 2'b11, rv); rd(3'd4, 2'b11, rv); check("R10 no auto data", rv, 16'hbeef);
    rd(3'd3, 2'b11, rv); check("R10 no auto ptr", rv, 16'h0010);
    wr(3'd3, 2'b11, 16'h47ff);
    wr(3'd4, 2'b11, 16'ha55a);
    rd(3'd3, 2'b11, rv); check("R10 wrap", rv, 16'h4001);
    wr(3'd3, 2'b11, 16'hffff); rd(3'd3, 2'b11, rv); check("R10 mask", rv, 16'he7ff);
  endtask

  task automatic t_mac;
    bank(3'd1);
    wr(3'd2, 2'b11, 16'h2211); check("R12 ia01", p_mac, 0);
    wr(3'd3, 2'b11, 16'h4433); check("R12 ia23", p_mac, 0);
    wr(3'd4, 2'b01, 16'h0055); check("R12 low lane", p_mac, 0);
    wr(3'd4, 2'b10, 16'h6600); check("R12 high lane", p_mac, 1);
    check("R12 mac", mac_o, 48'h6655_4433_2211);
    @(negedge clk); check("R13 mac width", mac_upd_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_merge(); t_rcr(); t_link(); t_mmu(); t_data(); t_mac();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule